// File: doc/BRIEF.md
# Variable-Slot Texture Coordinate Request Queue

This block queues texture coordinate requests on their way from one processor to the texture unit. Each request carries any non-empty subset of the four coordinate components s, t, r and b, together with a setup word. Only the written components take up storage, one word each, from a shared pool of eight coordinate slots. A request is taken in whole or not at all. The queue therefore holds eight s-only requests, four s-and-t requests, or two requests that carry all four components. All requesters on the processor share the one pool, and the queue has no notion of threads.

The texture unit takes one whole request per pop. The request arrives with its component mask and setup word, and each written component sits in its own lane. Popping a request returns all of its slots in the same cycle. A push and a pop may happen in the same cycle. A push with no components written is refused and raises an error flag.

A three-state controller tracks occupancy. The states are ST_EMPTY (all slots free), ST_PARTIAL (some slots used, some free) and ST_FULL (no slot free). The transitions are named as follows. `fill` goes from ST_EMPTY to ST_PARTIAL on an accepted push. `fill_all` goes from ST_EMPTY or ST_PARTIAL to ST_FULL when the last free slot is taken. `drain` goes from ST_PARTIAL to ST_EMPTY when the last used slot is returned. `release` goes from ST_FULL to ST_PARTIAL when a pop frees slots. `release_all` goes from ST_FULL to ST_EMPTY when that pop empties the pool. Every other cycle holds the current state.

Top module: `tex_coord_queue`

## Requirements
- R1: After reset, `free_slots` equals 8 and `pop_valid` is low.
- R2: `push_ready` is high exactly when `push_mask` is non-zero and its number of set bits is at most `free_slots`. A push is taken when both `push_valid` and `push_ready` are high. A refused push stores nothing.
- R3: An accepted push lowers `free_slots` by the number of set bits in its mask, from the next cycle on. `free_slots` never exceeds 8.
- R4: Starting from empty, the queue takes exactly eight pushes with mask 4'b0001, or four with mask 4'b0011, or two with mask 4'b1111. The push after that is refused.
- R5: While `pop_valid` is high, the pop port shows the oldest stored request: its mask, its setup word, and its coordinates. Requests leave in the order they were accepted. Lanes whose mask bit is clear read as zero.
- R6: A pop (`pop_valid` and `pop_ready` both high) returns all slots of that request. `free_slots` shows them in the next cycle. `pop_valid` is low exactly when all 8 slots are free.
- R7: When a push and a pop happen in the same cycle, `free_slots` changes by the net amount. `push_ready` is judged on the free count before the pop.
- R8: A push with `push_mask` equal to 4'b0000 raises `push_err` in the same cycle, keeps `push_ready` low, and stores nothing.
- R9: While `pop_valid` is high and `pop_ready` is low, the pop outputs stay unchanged.
- R10: Lane k of `push_coord` and `pop_coord` is bits [32k+31:32k]. Lane 0 is s (mask bit 0), lane 1 is t (bit 1), lane 2 is r (bit 2) and lane 3 is b (bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request present |
| push_mask | input | 4 | Written components: bit 0 s, bit 1 t, bit 2 r, bit 3 b |
| push_setup | input | 16 | Setup word that travels with the request |
| push_coord | input | 128 | Four 32-bit coordinate lanes; unwritten lanes are ignored |
| push_ready | output | 1 | Mask is legal and fits in the free slots |
| push_err | output | 1 | Push presented with an empty mask |
| free_slots | output | 4 | Number of free coordinate slots (0 to 8) |
| pop_valid | output | 1 | A request is available |
| pop_ready | input | 1 | Texture unit takes the request |
| pop_mask | output | 4 | Component mask of the oldest request |
| pop_setup | output | 16 | Setup word of the oldest request |
| pop_coord | output | 128 | Coordinates of the oldest request, with unwritten lanes at zero |

## Verification
The hardest case to reach from the ports is a pop whose request sits across the wrap point of the slot ring. In that case the lane indices cross from slot 7 back to slot 0, while pushes of a different size land in the same cycle. Directed fills bring the queue to its capacity limits. Then several thousand random cycles run with mixed mask sizes, including empty masks. A back-pressured pop side lets the queue fill, and a phase with eager pops lets it drain, so the head and tail pointers wrap many times at uneven offsets.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
    localparam int NCOMP = 4;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_PARTIAL,
        ST_FULL
    } tfq_state_e;

    // number of components written in a mask
    function automatic logic [2:0] comp_count(input logic [NCOMP-1:0] m);
        logic [2:0] n;
        n = '0;
        for (int i = 0; i < NCOMP; i++) n = n + {2'b00, m[i]};
        return n;
    endfunction

    // position of lane k among the packed slots of a request
    function automatic logic [2:0] lane_rank(input logic [NCOMP-1:0] m, input int k);
        logic [2:0] n;
        n = '0;
        for (int i = 0; i < NCOMP; i++)
            if (i < k) n = n + {2'b00, m[i]};
        return n;
    endfunction
endpackage

// File: rtl/tfq_slot_pool.sv
module tfq_slot_pool
    import tfq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int CW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [NCOMP-1:0]      wr_mask,
    input  logic [NCOMP*CW-1:0]   wr_lanes,
    input  logic                  rd_en,
    input  logic [NCOMP-1:0]      rd_mask,
    output logic [NCOMP*CW-1:0]   rd_lanes
);
    localparam int PW = $clog2(NSLOT);

    logic [CW-1:0] slot_q [NSLOT];
    logic [PW-1:0] head_q, tail_q;
    logic [PW-1:0] wr_idx [NCOMP];
    logic [PW-1:0] rd_idx [NCOMP];

    generate
        for (genvar k = 0; k < NCOMP; k++) begin : g_lane
            assign wr_idx[k] = tail_q + PW'(lane_rank(wr_mask, k));
            assign rd_idx[k] = head_q + PW'(lane_rank(rd_mask, k));
            assign rd_lanes[k*CW +: CW] = rd_mask[k] ? slot_q[rd_idx[k]] : '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int k = 0; k < NCOMP; k++)
            if (wr_en && wr_mask[k]) slot_q[wr_idx[k]] <= wr_lanes[k*CW +: CW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (wr_en) tail_q <= tail_q + PW'(comp_count(wr_mask));
            if (rd_en) head_q <= head_q + PW'(comp_count(rd_mask));
        end
    end
endmodule

// File: rtl/tfq_desc_queue.sv
module tfq_desc_queue
    import tfq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NCOMP-1:0] wr_mask,
    input  logic [SW-1:0]    wr_setup,
    input  logic             rd_en,
    output logic [NCOMP-1:0] head_mask,
    output logic [SW-1:0]    head_setup
);
    localparam int DW = $clog2(DEPTH);

    logic [NCOMP-1:0] mask_q  [DEPTH];
    logic [SW-1:0]    setup_q [DEPTH];
    logic [DW-1:0]    rd_ptr_q, wr_ptr_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mask_q[wr_ptr_q]  <= wr_mask;
            setup_q[wr_ptr_q] <= wr_setup;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
        end else begin
            if (wr_en) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (rd_en) rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    assign head_mask  = mask_q[rd_ptr_q];
    assign head_setup = setup_q[rd_ptr_q];
endmodule

// File: rtl/tfq_ctrl.sv
module tfq_ctrl
    import tfq_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int FW   = $clog2(NSLOT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [NCOMP-1:0] push_mask,
    input  logic             pop_ready,
    input  logic [NCOMP-1:0] head_mask,
    output logic             push_ready,
    output logic             push_err,
    output logic             pop_valid,
    output logic             push_fire,
    output logic             pop_fire,
    output logic [FW-1:0]    free_slots
);
    tfq_state_e state_q, state_d;
    logic [FW-1:0] free_q, free_d;
    logic [FW-1:0] push_cnt, pop_cnt;

    assign push_cnt = FW'(comp_count(push_mask));
    assign pop_cnt  = FW'(comp_count(head_mask));

    // next state and slot accounting
    always_comb begin
        free_d = free_q;
        if (push_fire) free_d = free_d - push_cnt;
        if (pop_fire)  free_d = free_d + pop_cnt;
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push_fire) state_d = (free_d == '0) ? ST_FULL : ST_PARTIAL; // fill / fill_all
            end
            ST_PARTIAL: begin
                if (free_d == FW'(NSLOT))  state_d = ST_EMPTY;   // drain
                else if (free_d == '0)     state_d = ST_FULL;    // fill_all
            end
            ST_FULL: begin
                if (pop_fire) state_d = (free_d == FW'(NSLOT)) ? ST_EMPTY : ST_PARTIAL; // release_all / release
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            free_q  <= FW'(NSLOT);
        end else begin
            state_q <= state_d;
            free_q  <= free_d;
        end
    end

    // outputs
    always_comb begin
        push_err   = push_valid && (push_mask == '0);
        push_ready = 1'b0;
        pop_valid  = 1'b0;
        unique case (state_q)
            ST_EMPTY:   push_ready = (push_mask != '0);
            ST_PARTIAL: begin
                push_ready = (push_mask != '0) && (push_cnt <= free_q);
                pop_valid  = 1'b1;
            end
            ST_FULL:    pop_valid = 1'b1;
            default:    push_ready = 1'b0;
        endcase
        push_fire  = push_valid && push_ready;
        pop_fire   = pop_valid && pop_ready;
        free_slots = free_q;
    end
endmodule

// File: rtl/tex_coord_queue.sv
module tex_coord_queue
    import tfq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int CW    = 32,
    parameter int SW    = 16,
    localparam int FW   = $clog2(NSLOT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [3:0]          push_mask,
    input  logic [SW-1:0]       push_setup,
    input  logic [4*CW-1:0]     push_coord,
    output logic                push_ready,
    output logic                push_err,
    output logic [FW-1:0]       free_slots,
    output logic                pop_valid,
    input  logic                pop_ready,
    output logic [3:0]          pop_mask,
    output logic [SW-1:0]       pop_setup,
    output logic [4*CW-1:0]     pop_coord
);
    logic push_fire, pop_fire;

    tfq_ctrl #(.NSLOT(NSLOT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_mask(push_mask),
        .pop_ready(pop_ready), .head_mask(pop_mask),
        .push_ready(push_ready), .push_err(push_err), .pop_valid(pop_valid),
        .push_fire(push_fire), .pop_fire(pop_fire), .free_slots(free_slots)
    );

    tfq_desc_queue #(.DEPTH(NSLOT), .SW(SW)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push_fire), .wr_mask(push_mask), .wr_setup(push_setup),
        .rd_en(pop_fire), .head_mask(pop_mask), .head_setup(pop_setup)
    );

    tfq_slot_pool #(.NSLOT(NSLOT), .CW(CW)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push_fire), .wr_mask(push_mask), .wr_lanes(push_coord),
        .rd_en(pop_fire), .rd_mask(pop_mask), .rd_lanes(pop_coord)
    );
endmodule

// File: rtl/tex_coord_queue_chk.sv
module tex_coord_queue_chk
    import tfq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int CW    = 32,
    parameter int SW    = 16,
    localparam int FW   = $clog2(NSLOT + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            push_valid,
    input logic [3:0]      push_mask,
    input logic            push_ready,
    input logic            push_err,
    input logic [FW-1:0]   free_slots,
    input logic            pop_valid,
    input logic            pop_ready,
    input logic [3:0]      pop_mask,
    input logic [SW-1:0]   pop_setup,
    input logic [4*CW-1:0] pop_coord
);
    int exp_next;
    logic [4*CW-1:0] lane_keep;

    always_comb begin
        exp_next = int'(free_slots);
        if (push_valid && push_ready) exp_next = exp_next - int'(comp_count(push_mask));
        if (pop_valid && pop_ready)   exp_next = exp_next + int'(comp_count(pop_mask));
        for (int k = 0; k < 4; k++) lane_keep[k*CW +: CW] = {CW{pop_mask[k]}};
    end

    // R3 R6 R7
    free_account_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> int'(free_slots) == $past(exp_next));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots <= FW'(NSLOT));

    // R6
    empty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |-> free_slots == FW'(NSLOT));

    // R8
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_mask == 4'b0000) |-> (push_err && !push_ready));

    // R5
    pop_mask_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> (pop_mask != 4'b0000 && (pop_coord & ~lane_keep) == '0));

    // R9
    pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_mask)
                                       && $stable(pop_setup) && $stable(pop_coord)));
endmodule

bind tex_coord_queue tex_coord_queue_chk #(.NSLOT(NSLOT), .CW(CW), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_mask(push_mask),
    .push_ready(push_ready), .push_err(push_err), .free_slots(free_slots),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_mask(pop_mask),
    .pop_setup(pop_setup), .pop_coord(pop_coord)
);

// File: tb/sim_tex_coord_queue.sv
module sim_tex_coord_queue;
    localparam int CW = 32;
    localparam int SW = 16;
    localparam int BW = 4 * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic [3:0] push_mask = '0;
    logic [SW-1:0] push_setup = '0;
    logic [BW-1:0] push_coord = '0;
    logic push_ready, push_err, pop_valid;
    logic pop_ready = 1'b0;
    logic [3:0] free_slots;
    logic [3:0] pop_mask;
    logic [SW-1:0] pop_setup;
    logic [BW-1:0] pop_coord;

    int checks = 0;
    int failures = 0;

    // reference model
    logic [3:0]    mq_mask [$];
    logic [SW-1:0] mq_setup [$];
    logic [BW-1:0] mq_coord [$];
    int mfree = 8;
    logic held = 1'b0;
    logic [BW-1:0] held_coord = '0;

    always #10 clk = ~clk; // 50 MHz

    tex_coord_queue u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_mask(push_mask),
        .push_setup(push_setup), .push_coord(push_coord), .push_ready(push_ready),
        .push_err(push_err), .free_slots(free_slots), .pop_valid(pop_valid),
        .pop_ready(pop_ready), .pop_mask(pop_mask), .pop_setup(pop_setup),
        .pop_coord(pop_coord)
    );

    function automatic int ncomp(input logic [3:0] m);
        return int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]);
    endfunction

    function automatic logic [BW-1:0] keep_lanes(input logic [3:0] m, input logic [BW-1:0] c);
        logic [BW-1:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) if (m[k]) r[k*CW +: CW] = c[k*CW +: CW];
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] m, input logic [SW-1:0] s,
                        input logic [BW-1:0] c, input logic pr);
        logic exp_ready, acc, pop;
        @(negedge clk);
        push_valid = v; push_mask = m; push_setup = s; push_coord = c; pop_ready = pr;
        #5;
        exp_ready = (m != 4'b0000) && (ncomp(m) <= mfree);
        chk(push_ready == exp_ready, "R2 push_ready", BW'(push_ready), BW'(exp_ready));
        chk(push_err == (v && m == 4'b0000), "R8 push_err", BW'(push_err), BW'(v && m == 4'b0000));
        chk(int'(free_slots) == mfree, "R3 R6 R7 free_slots", BW'(free_slots), BW'(mfree));
        chk(pop_valid == (mq_mask.size() > 0), "R6 pop_valid", BW'(pop_valid), BW'(mq_mask.size() > 0));
        if (mq_mask.size() > 0) begin
            chk(pop_mask == mq_mask[0], "R5 pop_mask", BW'(pop_mask), BW'(mq_mask[0]));
            chk(pop_setup == mq_setup[0], "R5 pop_setup", BW'(pop_setup), BW'(mq_setup[0]));
            chk(pop_coord == mq_coord[0], "R5 R10 pop_coord", pop_coord, mq_coord[0]);
        end
        if (held) chk(pop_coord == held_coord, "R9 held pop_coord", pop_coord, held_coord);
        held = pop_valid && !pr;
        held_coord = pop_coord;
        acc = v && exp_ready;
        pop = (mq_mask.size() > 0) && pr;
        @(posedge clk);
        if (pop) begin
            mfree = mfree + ncomp(mq_mask[0]);
            void'(mq_mask.pop_front()); void'(mq_setup.pop_front()); void'(mq_coord.pop_front());
        end
        if (acc) begin
            mfree = mfree - ncomp(m);
            mq_mask.push_back(m); mq_setup.push_back(s); mq_coord.push_back(keep_lanes(m, c));
        end
    endtask

    function automatic logic [BW-1:0] rnd_coord();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic drain();
        while (mq_mask.size() > 0) step(1'b0, 4'b0000, '0, '0, 1'b1);
    endtask

    task automatic fill_check(input logic [3:0] m, input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, m, SW'(i), rnd_coord(), 1'b0);
        @(negedge clk);
        push_valid = 1'b1; push_mask = m; pop_ready = 1'b0;
        #5;
        chk(push_ready == 1'b0, tag, BW'(push_ready), '0);
        chk(mq_mask.size() == n, tag, BW'(mq_mask.size()), BW'(n));
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20161));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(free_slots == 4'd8, "R1 reset free_slots", BW'(free_slots), BW'(8));
        chk(pop_valid == 1'b0, "R1 reset pop_valid", BW'(pop_valid), '0);

        // R4 capacities
        fill_check(4'b0001, 8, "R4 s-only capacity");
        fill_check(4'b0011, 4, "R4 st capacity");
        fill_check(4'b1111, 2, "R4 full-request capacity");

        // R8 empty mask stores nothing
        step(1'b1, 4'b0000, 16'hdead, rnd_coord(), 1'b0);
        step(1'b0, 4'b0000, '0, '0, 1'b0);

        // R7 full queue: push judged on pre-pop free count
        step(1'b1, 4'b1111, 16'h1, rnd_coord(), 1'b0);
        step(1'b1, 4'b1111, 16'h2, rnd_coord(), 1'b0);
        step(1'b1, 4'b0001, 16'h3, rnd_coord(), 1'b1);
        step(1'b1, 4'b0110, 16'h4, rnd_coord(), 1'b1);
        step(1'b1, 4'b1010, 16'h5, rnd_coord(), 1'b0);
        drain();

        // random phases: back-pressured, then eager pops
        for (int ph = 0; ph < 6; ph++) begin
            for (int i = 0; i < 500; i++) begin
                logic v, pr;
                logic [3:0] m;
                v = ($urandom % 4) != 0;
                m = 4'($urandom % 16);
                pr = (ph % 2 == 0) ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
                step(v, m, 16'($urandom), rnd_coord(), pr);
            end
        end
        drain();
        @(negedge clk);
        chk(free_slots == 4'd8, "R6 final free_slots", BW'(free_slots), BW'(8));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule